// File: doc/BRIEF.md
# Coil Saturation Fault Detector

This block watches the current regulators of two stepper-motor coils, X and Y. Each regulator reports the end of every PWM period and whether that period ran at full duty. A regulator stuck at full duty for too long means one of two things: the coil is open, or the supply cannot push the requested current through it. When a coil stays saturated past a fixed timeout, the block latches a per-coil fault flag. In open-coil mode it also turns off that coil's driver stage by requesting high impedance. Otherwise it only flags the condition, and the coil current keeps flowing.

The block also drives an active-low error output. This output combines the two coil flags with thermal warning, thermal shutdown, a vector of overcurrent flags, and a charge-pump fault. The charge-pump fault reads as set from power-on reset until a startup interval has elapsed. Host software clears a coil flag with a read strobe, but only when the coil's most recent period is no longer at full duty. A hard-clear input wipes the coil state without restarting the charge-pump startup interval.

Top module: `coilsat_monitor`

## Requirements
- R1: After an edge that accepts a full-duty period report for a coil, and with no later lower-duty report, that coil's flag rises on exactly the (TIMEOUT_TICKS+1)*CLK_PER_TICK-th following clock edge.
- R2: A period report with `period_full` low (`period_done[c]`=1, `period_full[c]`=0) stops the saturation timer and resets it to zero. The timeout is counted again in full from the next full-duty report.
- R3: Coil X is index 0 and coil Y is index 1 of every per-coil port. Saturation of one coil never changes the flag or driver-disable output of the other.
- R4: If `hiz_mode` is 1 on the edge where a coil's flag rises, that coil's `drv_hiz` bit rises with it. If `hiz_mode` is 0, the flag rises and `drv_hiz` stays 0. `drv_hiz` is never 1 while its flag is 0.
- R5: A latched flag and its `drv_hiz` bit persist until a `rd_stb` edge at which the coil's latest period report was not full duty. A read while the coil is still saturated leaves both bits set.
- R6: `err_n` is 0 when any of `therm_warn`, `therm_shut`, any `ovc_flags` bit, either coil flag, or `cp_fail` is 1. Otherwise it is 1.
- R7: `cp_fail` is 1 for the first CP_START_CYC clock edges after reset is released. After that it follows `cp_low`. `cp_low`=1 always gives `cp_fail`=1.
- R8: `hard_clr`=1 at an edge clears both flags, both `drv_hiz` bits and both saturation timers. It does not restart the charge-pump startup interval.
- R9: While `rst_n` is 0, both flags and both `drv_hiz` bits are 0, `cp_fail` is 1 and `err_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hard_clr | input | 1 | Synchronous hard clear of the coil state, active high |
| period_done | input | 2 | End-of-PWM-period strobe per coil (bit 0 = X, bit 1 = Y) |
| period_full | input | 2 | Period just ended ran at full duty; valid with `period_done` |
| hiz_mode | input | 1 | 1: put the driver in high impedance on detection |
| rd_stb | input | 1 | Status read strobe; clears flags whose condition has gone |
| therm_warn | input | 1 | Thermal warning |
| therm_shut | input | 1 | Thermal shutdown |
| ovc_flags | input | N_OVC | Overcurrent flags of the driver transistors |
| cp_low | input | 1 | Raw charge-pump undervoltage indication |
| coil_flag | output | 2 | Latched open/current-not-reached flag per coil |
| drv_hiz | output | 2 | Driver high-impedance request per coil |
| cp_fail | output | 1 | Charge-pump fault, including the startup interval |
| err_n | output | 1 | Active-low combined error output |

## Verification
The bench builds the block with CLK_PER_TICK=4, TIMEOUT_TICKS=5, CP_START_CYC=10 and N_OVC=4. With these values the saturation timeout is 24 clock edges and the startup interval is 10 edges. That makes the exact edge of flag assertion and of charge-pump release observable, with a one-edge margin on each side. The short timeout also lets the bench run several timer sequences within one run: a restart in mid-count, read-while-saturated, clear-after-release, and hard clear. The four-bit overcurrent vector allows the lowest and highest bits to be driven separately into the error output.

// File: rtl/coilsat_pkg.sv
// Package: shared constants and types for the coil saturation monitor.
// Assumes exactly two coils (X at index 0, Y at index 1).
package coilsat_pkg;

    localparam int NUM_COILS = 2;

    // Latched per-coil outcome of the saturation monitor.
    typedef struct packed {
        logic flag;   // open / current-not-reached latched
        logic hiz;    // driver high-impedance request
    } coil_status_t;

endpackage

// File: rtl/coilsat_coil_mon.sv
// Module: per-coil saturation timer and fault latch.
// Counts clock cycles through a local prescaler while the latest PWM period
// report of the coil was full duty. When the count passes TIMEOUT_TICKS
// prescaled ticks, it latches the flag and, in open-coil mode, the
// high-impedance request.
// Assumes period_full is only meaningful when period_done is 1.
module coilsat_coil_mon
    import coilsat_pkg::*;
#(
    parameter int CLK_PER_TICK  = 200000,
    parameter int TIMEOUT_TICKS = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hard_clr,
    input  logic         period_done,
    input  logic         period_full,
    input  logic         hiz_mode,
    input  logic         rd_stb,
    output coil_status_t status
);

    localparam int PRE_W  = $clog2(CLK_PER_TICK + 1);
    localparam int TICK_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(CLK_PER_TICK - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TIMEOUT_TICKS);

    logic              run_q;
    logic [PRE_W-1:0]  pre_q;
    logic [TICK_W-1:0] tick_q;
    coil_status_t      stat_q;

    logic tick_now;
    logic expire;
    logic restart;
    logic start;

    assign restart  = period_done && !period_full;
    assign start    = period_done && period_full;
    assign tick_now = run_q && (pre_q == PRE_LAST);
    assign expire   = tick_now && (tick_q == TICK_LAST);

    // Track whether the latest period report of this coil was full duty.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr) begin
            run_q <= 1'b0;
        end else if (restart) begin
            run_q <= 1'b0;
        end else if (start) begin
            run_q <= 1'b1;
        end
    end

    // Prescaler and tick counter; held at zero whenever saturation is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr || restart || !run_q) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick_now) begin
            pre_q <= '0;
            if (!expire) begin
                tick_q <= tick_q + 1'b1;
            end
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Latch the fault on expiry; clear on read once saturation has ended.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr) begin
            stat_q <= '0;
        end else if (expire) begin
            stat_q.flag <= 1'b1;
            stat_q.hiz  <= stat_q.hiz | hiz_mode;
        end else if (rd_stb && !run_q) begin
            stat_q <= '0;
        end
    end

    assign status = stat_q;

endmodule

// File: rtl/coilsat_cp_gate.sv
// Module: charge-pump fault qualifier.
// Reports a fault from power-on reset until CP_START_CYC clock edges have
// passed with reset released, and whenever the raw undervoltage input is
// high. Only rst_n restarts the interval; the pump keeps running through a
// hard clear.
module coilsat_cp_gate #(
    parameter int CP_START_CYC = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cp_low,
    output logic cp_fail
);

    localparam int CNT_W = $clog2(CP_START_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(CP_START_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             pending;

    assign pending = (cnt_q != CNT_DONE);

    // Count the startup interval once after reset release, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pending) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cp_fail = pending || cp_low;

endmodule

// File: rtl/coilsat_err_merge.sv
// Module: active-low error output combiner.
// Assumes all inputs are already synchronous to clk; purely combinational.
module coilsat_err_merge
    import coilsat_pkg::*;
#(
    parameter int N_OVC = 8
) (
    input  logic                 therm_warn,
    input  logic                 therm_shut,
    input  logic [N_OVC-1:0]     ovc_flags,
    input  logic [NUM_COILS-1:0] coil_flag,
    input  logic                 cp_fail,
    output logic                 err_n
);

    logic any_fault;

    // Any single fault source pulls the error output low.
    always_comb begin
        any_fault = therm_warn | therm_shut | cp_fail;
        any_fault = any_fault | (|ovc_flags) | (|coil_flag);
        err_n     = ~any_fault;
    end

endmodule

// File: rtl/coilsat_monitor.sv
// Module: top of the coil saturation fault detector.
// Instantiates one saturation monitor per coil, the charge-pump qualifier
// and the error combiner. Assumes all inputs are synchronous to clk.
module coilsat_monitor
    import coilsat_pkg::*;
#(
    parameter int CLK_PER_TICK  = 200000,
    parameter int TIMEOUT_TICKS = 200,
    parameter int CP_START_CYC  = 1000000,
    parameter int N_OVC         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_clr,
    input  logic [1:0]       period_done,
    input  logic [1:0]       period_full,
    input  logic             hiz_mode,
    input  logic             rd_stb,
    input  logic             therm_warn,
    input  logic             therm_shut,
    input  logic [N_OVC-1:0] ovc_flags,
    input  logic             cp_low,
    output logic [1:0]       coil_flag,
    output logic [1:0]       drv_hiz,
    output logic             cp_fail,
    output logic             err_n
);

    coil_status_t coil_st [NUM_COILS];

    // One independent saturation monitor per coil.
    for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
        coilsat_coil_mon #(
            .CLK_PER_TICK (CLK_PER_TICK),
            .TIMEOUT_TICKS(TIMEOUT_TICKS)
        ) u_mon (
            .clk        (clk),
            .rst_n      (rst_n),
            .hard_clr   (hard_clr),
            .period_done(period_done[c]),
            .period_full(period_full[c]),
            .hiz_mode   (hiz_mode),
            .rd_stb     (rd_stb),
            .status     (coil_st[c])
        );
        assign coil_flag[c] = coil_st[c].flag;
        assign drv_hiz[c]   = coil_st[c].hiz;
    end

    coilsat_cp_gate #(
        .CP_START_CYC(CP_START_CYC)
    ) u_cp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cp_low (cp_low),
        .cp_fail(cp_fail)
    );

    coilsat_err_merge #(
        .N_OVC(N_OVC)
    ) u_err (
        .therm_warn(therm_warn),
        .therm_shut(therm_shut),
        .ovc_flags (ovc_flags),
        .coil_flag (coil_flag),
        .cp_fail   (cp_fail),
        .err_n     (err_n)
    );

endmodule

// File: rtl/coilsat_monitor_chk.sv
// Module: assertion checker for coilsat_monitor, attached by bind.
// Observes only the ports of the top module.
module coilsat_monitor_chk #(
    parameter int N_OVC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hard_clr,
    input logic [1:0]       period_done,
    input logic [1:0]       period_full,
    input logic             rd_stb,
    input logic             therm_warn,
    input logic             therm_shut,
    input logic [N_OVC-1:0] ovc_flags,
    input logic             cp_low,
    input logic [1:0]       coil_flag,
    input logic [1:0]       drv_hiz,
    input logic             cp_fail,
    input logic             err_n
);

    // R4
    hiz_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_hiz & ~coil_flag) == 2'b00);

    // R8
    hard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_clr |=> (coil_flag == 2'b00 && drv_hiz == 2'b00));

    // R7
    cp_low_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_low |-> cp_fail);

    // R6
    fault_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_warn || therm_shut || (|ovc_flags)) |-> !err_n);

    // R6
    flag_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|coil_flag) |-> !err_n);

    for (genvar c = 0; c < 2; c++) begin : g_coil_chk
        // R5
        flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(coil_flag[c]) |-> $past(rd_stb || hard_clr));

        // R2
        no_rise_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(coil_flag[c]) |-> !$past(period_done[c] && !period_full[c]));
    end

endmodule

bind coilsat_monitor coilsat_monitor_chk #(.N_OVC(N_OVC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_clr   (hard_clr),
    .period_done(period_done),
    .period_full(period_full),
    .rd_stb     (rd_stb),
    .therm_warn (therm_warn),
    .therm_shut (therm_shut),
    .ovc_flags  (ovc_flags),
    .cp_low     (cp_low),
    .coil_flag  (coil_flag),
    .drv_hiz    (drv_hiz),
    .cp_fail    (cp_fail),
    .err_n      (err_n)
);

// File: tb/tb_coilsat_monitor.sv
`timescale 1ns/100ps
module tb_coilsat_monitor;

    localparam int CPT   = 4;
    localparam int TO    = 5;
    localparam int CPS   = 10;
    localparam int NOVC  = 4;
    localparam int LIMIT = (TO + 1) * CPT;   // edges from full report to flag

    // Vector: [8] warn [7] shut [6:3] ovc [2] cp_low [1] exp err_n [0] exp cp_fail
    localparam logic [8:0] VEC [8] = '{
        9'b0_0_0000_0_1_0,
        9'b1_0_0000_0_0_0,
        9'b0_1_0000_0_0_0,
        9'b0_0_0001_0_0_0,
        9'b0_0_1000_0_0_0,
        9'b0_0_0000_1_0_1,
        9'b1_1_1111_1_0_1,
        9'b0_0_0000_0_1_0
    };

    logic            clk = 1'b0;
    logic            rst_n, hard_clr, hiz_mode, rd_stb;
    logic [1:0]      period_done, period_full;
    logic            therm_warn, therm_shut, cp_low;
    logic [NOVC-1:0] ovc_flags;
    logic [1:0]      coil_flag, drv_hiz;
    logic            cp_fail, err_n;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    coilsat_monitor #(
        .CLK_PER_TICK (CPT),
        .TIMEOUT_TICKS(TO),
        .CP_START_CYC (CPS),
        .N_OVC        (NOVC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .hard_clr(hard_clr),
        .period_done(period_done), .period_full(period_full),
        .hiz_mode(hiz_mode), .rd_stb(rd_stb),
        .therm_warn(therm_warn), .therm_shut(therm_shut),
        .ovc_flags(ovc_flags), .cp_low(cp_low),
        .coil_flag(coil_flag), .drv_hiz(drv_hiz),
        .cp_fail(cp_fail), .err_n(err_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic report(input string reason);
        if (reason != "") $display("%s", reason);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic period(input logic [1:0] done, input logic [1:0] full);
        period_done = done;
        period_full = full;
        step(1);
        period_done = 2'b00;
        period_full = 2'b00;
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        step(1);
        rd_stb = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_err++;
        report("FAIL watchdog expired");
    end

    initial begin
        rst_n = 0; hard_clr = 0; hiz_mode = 0; rd_stb = 0;
        period_done = 0; period_full = 0;
        therm_warn = 0; therm_shut = 0; cp_low = 0; ovc_flags = '0;
        step(3);
        // R9 reset state
        chk("R9 coil_flag in reset", coil_flag, 2'b00);
        chk("R9 drv_hiz in reset", drv_hiz, 2'b00);
        chk("R9 cp_fail in reset", cp_fail, 1'b1);
        chk("R9 err_n in reset", err_n, 1'b0);

        rst_n = 1;
        step(CPS - 1);
        chk("R7 cp_fail inside startup", cp_fail, 1'b1);
        step(1);
        chk("R7 cp_fail after startup", cp_fail, 1'b0);

        // R6 / R7 table of fault input patterns
        for (int i = 0; i < 8; i++) begin
            therm_warn = VEC[i][8];
            therm_shut = VEC[i][7];
            ovc_flags  = VEC[i][6:3];
            cp_low     = VEC[i][2];
            step(1);
            chk($sformatf("R6 err_n vector %0d", i), err_n, VEC[i][1]);
            chk($sformatf("R7 cp_fail vector %0d", i), cp_fail, VEC[i][0]);
        end

        // R1 / R4 coil X timeout in open-coil mode
        hiz_mode = 1;
        period(2'b01, 2'b01);
        step(LIMIT - 1);
        chk("R1 X flag one edge early", coil_flag[0], 1'b0);
        step(1);
        chk("R1 X flag at timeout", coil_flag[0], 1'b1);
        chk("R4 X hiz in open mode", drv_hiz[0], 1'b1);
        chk("R3 Y untouched by X", {coil_flag[1], drv_hiz[1]}, 2'b00);
        chk("R6 err_n with coil flag", err_n, 1'b0);

        // R2 coil Y restart mid-count, R4 keep-current mode
        hiz_mode = 0;
        period(2'b10, 2'b10);
        step(10);
        period(2'b10, 2'b00);
        period(2'b10, 2'b10);
        step(LIMIT - 1);
        chk("R2 Y flag one edge early after restart", coil_flag[1], 1'b0);
        step(1);
        chk("R2 Y flag after full count", coil_flag[1], 1'b1);
        chk("R4 Y no hiz in keep-current mode", drv_hiz[1], 1'b0);
        chk("R5 X flag persists", {coil_flag[0], drv_hiz[0]}, 2'b11);

        // R5 read while saturated has no effect
        do_read();
        chk("R5 read while saturated keeps flags", coil_flag, 2'b11);
        chk("R5 read while saturated keeps hiz", drv_hiz, 2'b01);

        // R5 X released then read
        period(2'b01, 2'b00);
        do_read();
        chk("R5 X cleared after release", {coil_flag[0], drv_hiz[0]}, 2'b00);
        chk("R5 Y still saturated keeps flag", coil_flag[1], 1'b1);
        period(2'b10, 2'b00);
        do_read();
        chk("R5 Y cleared after release", coil_flag[1], 1'b0);
        chk("R6 err_n idle", err_n, 1'b1);

        // R8 hard clear
        hiz_mode = 1;
        period(2'b01, 2'b01);
        step(LIMIT + 5);
        chk("R8 X flag set before hard clear", coil_flag[0], 1'b1);
        hard_clr = 1;
        step(1);
        hard_clr = 0;
        chk("R8 flags cleared", coil_flag, 2'b00);
        chk("R8 hiz cleared", drv_hiz, 2'b00);
        chk("R8 cp startup not restarted", cp_fail, 1'b0);
        step(LIMIT + 5);
        chk("R8 timer cleared by hard clear", coil_flag, 2'b00);

        report("");
    end

endmodule